// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock waveform for an I2C master. It holds two pairs of cycle counts, one pair for standard-mode timing and one for fast-mode timing, and a speed field in its control register selects the pair in use. When the block is enabled and the bit engine asks for clocks, it first waits out a start-hold interval with the line released. It then alternates low phases, where it drives SCL low, with high phases, where it releases the line. The output is an open-drain drive-low signal, together with two one-cycle strobes that mark the falling and rising edges for the bit engine.

Each count carries a fixed hardware offset. The low phase begins counting in the same cycle the block starts to pull SCL low. The high phase counts only on cycles where the sensed line reads high, so a slave that holds SCL low lengthens the phase one cycle at a time. Counts below a floor are raised to that floor. The control and count registers accept writes only while the block is disabled.

Top module: `scl_period_gen`

## Requirements
- R1: Registers are written on a clock edge where reg_wr is high, at these byte addresses: control 0x00, standard-mode high count 0x14, standard-mode low count 0x18, fast-mode high count 0x1C, fast-mode low count 0x20, enable 0x6C (bit 0 of the data).
- R2: Control bits [2:1] equal to 2'b10 (data value 0x4) select the fast-mode pair. Any other value, including 2'b01 (data value 0x2), selects the standard-mode pair. After reset, standard mode is selected.
- R3: A low phase holds scl_drive_low high for exactly L+1 consecutive cycles, where L is the effective low count, starting in the first cycle of the phase.
- R4: A high phase keeps scl_drive_low low for H+8 cycles in which scl_in reads high, where H is the effective high count. Each cycle in which scl_in reads low adds one cycle to the phase.
- R5: When run_req is seen while the block is enabled and idle, busy rises and the line stays released for exactly H+3 cycles before the first low phase.
- R6: Writes to the control register or to any count register are ignored while the block is enabled. The enable register can be written at any time.
- R7: At the end of a high phase, the next low phase starts in the following cycle if run_req is high. Otherwise the block returns to idle and busy falls.
- R8: A write of 0 to the enable register releases the line and clears busy on the next cycle, whatever phase is in progress.
- R9: The effective high count is the larger of the programmed value and 6. The effective low count is the larger of the programmed value and 8.
- R10: fall_stb is high only in the first cycle of each low phase, and rise_stb is high only in the first cycle of each high phase.
- R11: After reset, scl_drive_low, busy, fall_stb and rise_stb are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Register byte address |
| reg_wdata | input | CW (16) | Register write data |
| run_req | input | 1 | Request from the bit engine to keep clocks running |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | Pull SCL low when high (open-drain drive) |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| busy | output | 1 | Block is generating the start hold or clock phases |

## Verification
A run request is accepted at the next clock edge, and the first low phase is then due H+3 cycles later. Each phase switch takes effect at the edge where the counter reaches zero, so the drive and strobe outputs change one edge after the last counted cycle. A disable write takes effect at the edge that captures it. The bench drives inputs and samples outputs on the falling clock edge and measures each phase as a run of consecutive samples. Because it counts samples rather than waiting fixed delays, the expected values H+3, L+1 and H+8 plus the number of stretch cycles are compared with the measured lengths directly. Strobes are checked at the first sample of each phase.

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int AW        = 8,
  parameter int CW        = 16,
  parameter int HI_MIN    = 6,
  parameter int LO_MIN    = 8,
  parameter int HI_OVH    = 8,
  parameter int HOLD_OVH  = 3,
  parameter int RST_SS_HI = 20,
  parameter int RST_SS_LO = 25,
  parameter int RST_FS_HI = 8,
  parameter int RST_FS_LO = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  input  logic          run_req,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          fall_stb,
  output logic          rise_stb,
  output logic          busy
);
  localparam int NW = CW + 4;
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h00);
  localparam logic [AW-1:0] A_SS_HI = AW'(8'h14);
  localparam logic [AW-1:0] A_SS_LO = AW'(8'h18);
  localparam logic [AW-1:0] A_FS_HI = AW'(8'h1C);
  localparam logic [AW-1:0] A_FS_LO = AW'(8'h20);
  localparam logic [AW-1:0] A_EN    = AW'(8'h6C);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_LOW, S_HIGH} st_t;

  st_t st, st_prev;
  logic [NW-1:0] cnt;
  logic [CW-1:0] ss_hi_q, ss_lo_q, fs_hi_q, fs_lo_q;
  logic [1:0]    speed_q;
  logic          en_q;

  logic          cfg_wr, dis_wr, fast;
  logic [CW-1:0] hi_sel, lo_sel;
  logic [NW-1:0] hi_eff, lo_eff;

  assign cfg_wr = reg_wr && !en_q;
  assign dis_wr = reg_wr && (reg_addr == A_EN) && !reg_wdata[0];
  assign fast   = (speed_q == 2'b10);
  assign hi_sel = fast ? fs_hi_q : ss_hi_q;
  assign lo_sel = fast ? fs_lo_q : ss_lo_q;
  assign hi_eff = (hi_sel < CW'(HI_MIN)) ? NW'(HI_MIN) : NW'(hi_sel);
  assign lo_eff = (lo_sel < CW'(LO_MIN)) ? NW'(LO_MIN) : NW'(lo_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_hi_q <= CW'(RST_SS_HI);
      ss_lo_q <= CW'(RST_SS_LO);
      fs_hi_q <= CW'(RST_FS_HI);
      fs_lo_q <= CW'(RST_FS_LO);
      speed_q <= 2'b01;
      en_q    <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata[0];
      if (cfg_wr) begin
        case (reg_addr)
          A_CTRL:  speed_q <= reg_wdata[2:1];
          A_SS_HI: ss_hi_q <= reg_wdata;
          A_SS_LO: ss_lo_q <= reg_wdata;
          A_FS_HI: fs_hi_q <= reg_wdata;
          A_FS_LO: fs_lo_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      st_prev <= S_IDLE;
      cnt     <= '0;
    end else begin
      st_prev <= st;
      if (dis_wr || !en_q) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDLE:
            if (run_req) begin
              st  <= S_HOLD;
              cnt <= hi_eff + NW'(HOLD_OVH - 1);
            end
          S_HOLD:
            if (cnt == '0) begin
              st  <= S_LOW;
              cnt <= lo_eff;
            end else cnt <= cnt - 1'b1;
          S_LOW:
            if (cnt == '0) begin
              st  <= S_HIGH;
              cnt <= hi_eff + NW'(HI_OVH - 1);
            end else cnt <= cnt - 1'b1;
          S_HIGH:
            if (scl_in) begin
              if (cnt == '0) begin
                if (run_req) begin
                  st  <= S_LOW;
                  cnt <= lo_eff;
                end else st <= S_IDLE;
              end else cnt <= cnt - 1'b1;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign scl_drive_low = (st == S_LOW);
  assign busy          = (st != S_IDLE);
  assign fall_stb      = (st == S_LOW)  && (st_prev != S_LOW);
  assign rise_stb      = (st == S_HIGH) && (st_prev != S_HIGH);

  logic [NW-1:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_run <= '0;
    else        lo_run <= scl_drive_low ? lo_run + 1'b1 : '0;
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> ($stable(ss_hi_q) && $stable(ss_lo_q) &&
      $stable(fs_hi_q) && $stable(fs_lo_q) && $stable(speed_q))); // R6
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> (!scl_drive_low && !busy)); // R8
  AST_LOW_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && !$past(dis_wr)) |-> (lo_run >= NW'(LO_MIN + 1))); // R3
  AST_HIGH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && !scl_in && en_q && !dis_wr) |=> (st == S_HIGH && $stable(cnt))); // R4
  AST_FALL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> fall_stb); // R10
  AST_LOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> ($past(st) == S_HOLD || $past(st) == S_HIGH)); // R7
endmodule

// File: tb/scl_period_gen_tb.sv
module scl_period_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic run_req = 1'b0, slave_hold = 1'b0;
  logic scl_in, scl_drive_low, fall_stb, rise_stb, busy;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  assign scl_in = !scl_drive_low && !slave_hold;

  scl_period_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .run_req(run_req), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic measure(input int stretch, input bit keep,
                         output int hold_c, output int lo_c, output int hi_c,
                         output bit fs_ok, output bit rs_ok);
    @(negedge clk);
    run_req = 1'b1;
    hold_c = 0;
    @(negedge clk);
    while (!scl_drive_low) begin hold_c++; @(negedge clk); end
    fs_ok = fall_stb;
    lo_c = 0;
    while (scl_drive_low) begin
      lo_c++;
      if (lo_c > 1 && fall_stb) fs_ok = 1'b0;
      @(negedge clk);
    end
    rs_ok = rise_stb;
    if (!keep) run_req = 1'b0;
    hi_c = 0;
    if (stretch > 0) begin
      slave_hold = 1'b1;
      for (int i = 0; i < stretch; i++) begin hi_c++; @(negedge clk); end
      slave_hold = 1'b0;
    end
    while (busy && !scl_drive_low) begin
      if (hi_c > 0 && rise_stb) rs_ok = 1'b0;
      hi_c++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check(!scl_drive_low, "R11 drive", int'(scl_drive_low), 0);
    check(!busy, "R11 busy", int'(busy), 0);
    check(!fall_stb && !rise_stb, "R11 strobes", int'({fall_stb, rise_stb}), 0);
  endtask

  task automatic run_expect(input string tag, input int stretch, input int h, input int l);
    int hc, lc, ic; bit fo, ro;
    measure(stretch, 1'b0, hc, lc, ic, fo, ro);
    check(hc == h + 3, {tag, " R5 hold"}, hc, h + 3);
    check(lc == l + 1, {tag, " R3 low"}, lc, l + 1);
    check(ic == h + 8 + stretch, {tag, " R4 high"}, ic, h + 8 + stretch);
    check(!busy, {tag, " R7 idle"}, int'(busy), 0);
    check(fo && ro, {tag, " R10 strobes"}, int'({fo, ro}), 3);
  endtask

  task automatic t_standard;
    wr(8'h6C, 16'h1);
    run_expect("std default R2", 0, 20, 25);
  endtask

  task automatic t_fast;
    wr(8'h6C, 16'h0);
    wr(8'h00, 16'h4);
    wr(8'h1C, 16'd10);
    wr(8'h20, 16'd12);
    wr(8'h6C, 16'h1);
    run_expect("fast R2 R1", 0, 10, 12);
  endtask

  task automatic t_back_to_std;
    wr(8'h6C, 16'h0);
    wr(8'h00, 16'h2);
    wr(8'h14, 16'd30);
    wr(8'h18, 16'd9);
    wr(8'h6C, 16'h1);
    run_expect("std R1", 0, 30, 9);
  endtask

  task automatic t_stretch;
    run_expect("stretch R4", 5, 30, 9);
  endtask

  task automatic t_locked;
    wr(8'h18, 16'd50);
    wr(8'h14, 16'd7);
    wr(8'h00, 16'h4);
    run_expect("locked R6", 0, 30, 9);
  endtask

  task automatic t_clamp;
    wr(8'h6C, 16'h0);
    wr(8'h14, 16'd2);
    wr(8'h18, 16'd3);
    wr(8'h6C, 16'h1);
    run_expect("clamp R9", 0, 6, 8);
  endtask

  task automatic t_continuous;
    int hc, lc, ic, lc2; bit fo, ro;
    measure(0, 1'b1, hc, lc, ic, fo, ro);
    check(ic == 14, "R7 high before next low", ic, 14);
    check(scl_drive_low && fall_stb, "R7 next low starts", int'({scl_drive_low, fall_stb}), 3);
    run_req = 1'b0;
    lc2 = 0;
    while (scl_drive_low) begin lc2++; @(negedge clk); end
    check(lc2 == 9, "R7 R3 second low", lc2, 9);
    while (busy) @(negedge clk);
  endtask

  task automatic t_disable;
    @(negedge clk);
    run_req = 1'b1;
    while (!scl_drive_low) @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h6C; reg_wdata = 16'h0;
    @(negedge clk);
    reg_wr = 1'b0;
    check(!scl_drive_low && !busy, "R8 disable release", int'({scl_drive_low, busy}), 0);
    repeat (3) @(negedge clk);
    check(!busy, "R8 stays idle while disabled", int'(busy), 0);
    run_req = 1'b0;
  endtask

  initial begin
    while (!done && cycles < WATCHDOG) begin @(posedge clk); cycles++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_standard;
    t_fast;
    t_back_to_std;
    t_stretch;
    t_locked;
    t_clamp;
    t_continuous;
    t_disable;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule